// File: doc/BRIEF.md
# Serial Interface Resync Reset Detector

This block sits on the data-in line of a clocked serial register port. It resets the whole device when the host clocks in a long unbroken run of one bits. A host whose bit framing has drifted, for example after a glitch on the serial clock, cannot rely on any command being decoded correctly. It can always send a string of ones, though, and the block uses that string to bring the port back into step. On that pattern the block drives a single-cycle reset to the register file, the interface logic, the digital filter and the modulator control. The same reset is raised at power-on.

After every reset a lockout counter keeps `accessBusy` high for a fixed recovery time, which is 500 µs by default. Register accesses are refused while the flag is high. The serial clock, data and select pins are synchronised into the system clock domain. Bits are sampled on the detected rising edges of the serial clock. A bit counts only while the port is selected and the block is not busy.

Top module: `sif_resync_reset`

## Requirements
- R1: While `porN` is low, `devReset` and `accessBusy` are both high. On the first clock after `porN` rises, `devReset` goes low and `accessBusy` stays high.
- R2: A bit is the level of `sdi` at a rising edge of `sclk` while `csN` is low (active low). A level of 1 counts as a one. When the RUN_LEN-th consecutive one is sampled (32 by default), `devReset` is high in the third system clock cycle after that `sclk` edge reaches the pins.
- R3: A `devReset` pulse caused by a run of ones lasts exactly one system clock cycle.
- R4: A 0 bit clears the run. A reset then needs RUN_LEN fresh ones.
- R5: Raising `csN` clears the run, so the ones must all fall inside one selected transfer.
- R6: After `devReset` falls, or after `porN` rises, `accessBusy` stays high for exactly HOLD+1 further cycles, where HOLD = CLK_KHZ*LOCKOUT_US/1000.
- R7: Bits sampled while `accessBusy` is high are ignored and do not add to a run.
- R8: Rising edges of `sclk` while `csN` is high are never counted, however many ones are clocked.
- R9: In a long transfer, counting restarts once the lockout ends. A further RUN_LEN ones that are sampled after that give a second reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| sclk | input | 1 | Serial clock from the host (asynchronous) |
| sdi | input | 1 | Serial data in from the host |
| csN | input | 1 | Serial chip select, active low |
| devReset | output | 1 | Device-wide reset pulse, active high |
| accessBusy | output | 1 | High while register access is locked out |

## Verification
A serial edge on the pins reaches the synchroniser output after two clocks. The edge detector and the state register add one more clock, so a reset pulse is due exactly three system cycles after the `sclk` rising edge that carries the triggering bit. The bench samples `devReset` in that cycle for every bit it sends, and compares the sample with a per-bit model of the run count. The model also knows how many later bits fall inside the lockout: that number is (HOLD+2) divided by the bit period. The lockout length is checked by counting the busy cycles after the pulse and comparing the count with HOLD+1. Pulse width is checked in the same way.

// File: rtl/sif_rr_pkg.sv
package sif_rr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FIRE = 2'd1,
    ST_LOCK = 2'd2
  } rrState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrRun;
    logic incRun;
    logic loadHold;
    logic decHold;
  } ctlStrobe_t;

endpackage

// File: rtl/sif_rr_sync.sv
module sif_rr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclkIn,
  input  logic sdiIn,
  input  logic csNIn,
  output logic bitStrobe,
  output logic bitVal,
  output logic csActive
);
  // lane order: [2]=csN, [1]=sdi, [0]=sclk
  localparam logic [2:0] RST_VAL = 3'b100;

  logic [2:0] stage [STAGES];
  logic       sclkPrev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[0] <= RST_VAL;
          else       stage[0] <= {csNIn, sdiIn, sclkIn};
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[g] <= RST_VAL;
          else       stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= stage[STAGES-1][0];
  end

  assign bitStrobe = stage[STAGES-1][0] & ~sclkPrev;
  assign bitVal    = stage[STAGES-1][1];
  assign csActive  = ~stage[STAGES-1][2];
endmodule

// File: rtl/sif_rr_dp.sv
module sif_rr_dp
  import sif_rr_pkg::*;
#(
  parameter int RUN_LEN = 32,
  parameter int HOLD    = 25000,
  localparam int RUN_W  = $clog2(RUN_LEN + 1),
  localparam int HOLD_W = $clog2(HOLD + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       stb,
  output logic             runLast,
  output logic             holdZero,
  output logic [RUN_W-1:0] runCount
);
  logic [HOLD_W-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           runCount <= '0;
    else if (stb.clrRun) runCount <= '0;
    else if (stb.incRun) runCount <= runCount + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             holdCnt <= '0;
    else if (stb.loadHold) holdCnt <= HOLD_W'(HOLD);
    else if (stb.decHold)  holdCnt <= holdCnt - 1'b1;
  end

  assign runLast  = (runCount == RUN_W'(RUN_LEN - 1));
  assign holdZero = (holdCnt == '0);
endmodule

// File: rtl/sif_rr_ctrl.sv
module sif_rr_ctrl
  import sif_rr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitStrobe,
  input  logic       bitVal,
  input  logic       csActive,
  input  logic       runLast,
  input  logic       holdZero,
  output ctlStrobe_t stb,
  output logic       fire,
  output logic       busy
);
  rrState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_FIRE;   // power-on behaves like a triggered reset
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    unique case (state)
      ST_IDLE: begin
        if (!csActive) begin
          stb.clrRun = 1'b1;
        end else if (bitStrobe) begin
          if (!bitVal) begin
            stb.clrRun = 1'b1;
          end else if (runLast) begin
            stb.clrRun = 1'b1;
            stateNext  = ST_FIRE;
          end else begin
            stb.incRun = 1'b1;
          end
        end
      end
      ST_FIRE: begin
        stb.clrRun   = 1'b1;
        stb.loadHold = 1'b1;
        stateNext    = ST_LOCK;
      end
      ST_LOCK: begin
        stb.clrRun = 1'b1;
        if (holdZero) stateNext   = ST_IDLE;
        else          stb.decHold = 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign fire = (state == ST_FIRE);
  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/sif_resync_reset.sv
module sif_resync_reset #(
  parameter int RUN_LEN     = 32,
  parameter int SYNC_STAGES = 2,
  parameter int CLK_KHZ     = 50000,
  parameter int LOCKOUT_US  = 500
) (
  input  logic sysClk,
  input  logic porN,
  input  logic sclk,
  input  logic sdi,
  input  logic csN,
  output logic devReset,
  output logic accessBusy
);
  import sif_rr_pkg::*;

  localparam int HOLD  = CLK_KHZ * LOCKOUT_US / 1000;
  localparam int RUN_W = $clog2(RUN_LEN + 1);

  logic             bitStrobe, bitVal, csActive;
  logic             runLast, holdZero;
  logic [RUN_W-1:0] runCount;
  ctlStrobe_t       stb;

  sif_rr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(sysClk), .rstN(porN),
    .sclkIn(sclk), .sdiIn(sdi), .csNIn(csN),
    .bitStrobe(bitStrobe), .bitVal(bitVal), .csActive(csActive)
  );

  sif_rr_ctrl u_ctrl (
    .clk(sysClk), .rstN(porN),
    .bitStrobe(bitStrobe), .bitVal(bitVal), .csActive(csActive),
    .runLast(runLast), .holdZero(holdZero),
    .stb(stb), .fire(devReset), .busy(accessBusy)
  );

  sif_rr_dp #(.RUN_LEN(RUN_LEN), .HOLD(HOLD)) u_dp (
    .clk(sysClk), .rstN(porN), .stb(stb),
    .runLast(runLast), .holdZero(holdZero), .runCount(runCount)
  );
endmodule

// File: rtl/sif_resync_reset_chk.sv
module sif_resync_reset_chk #(
  parameter int RUN_LEN = 32,
  parameter int HOLD    = 25000,
  parameter int RUN_W   = 6
) (
  input logic             clk,
  input logic             porN,
  input logic             devReset,
  input logic             accessBusy,
  input logic             csActive,
  input logic [RUN_W-1:0] runCount
);
  int busyLen;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                        busyLen <= 0;
    else if (accessBusy && !devReset) busyLen <= busyLen + 1;
    else                              busyLen <= 0;
  end

  // R3: single-cycle pulse, followed by lockout
  a_r3_pulse_single: assert property (@(posedge clk) disable iff (!porN)
    devReset |=> (!devReset && accessBusy));

  // R6: lockout length after the pulse
  a_r6_busy_len: assert property (@(posedge clk) disable iff (!porN)
    $fell(accessBusy) |-> (busyLen == HOLD + 1));

  // R5: deselect clears the run
  a_r5_desel_clear: assert property (@(posedge clk) disable iff (!porN)
    !csActive |=> (runCount == '0));

  // R7: nothing accumulates during lockout
  a_r7_busy_clear: assert property (@(posedge clk) disable iff (!porN)
    accessBusy |=> (runCount == '0));

  // R2: the run never passes the trigger length
  a_r2_run_bound: assert property (@(posedge clk) disable iff (!porN)
    runCount < RUN_W'(RUN_LEN));
endmodule

bind sif_resync_reset sif_resync_reset_chk #(
  .RUN_LEN(RUN_LEN), .HOLD(HOLD), .RUN_W(RUN_W)
) u_chk (
  .clk(sysClk), .porN(porN), .devReset(devReset), .accessBusy(accessBusy),
  .csActive(csActive), .runCount(runCount)
);

// File: tb/test_sif_resync_reset.sv
module test_sif_resync_reset;
  localparam int RUN  = 32;
  localparam int KHZ  = 40;
  localparam int LUS  = 500;
  localparam int HOLD = KHZ * LUS / 1000;      // 20
  localparam int HALF = 4;
  localparam int PER  = HALF + 5;              // system cycles per bit
  localparam int SKIP = (HOLD + 2) / PER;      // bits lost in the lockout

  logic clk = 1'b0;
  logic porN = 1'b0, sclk = 1'b0, sdi = 1'b0, csN = 1'b1;
  logic devReset, accessBusy;

  int checks = 0, failures = 0;
  int mRun = 0, mSkip = 0, mPulses = 0;
  int pulses = 0, pw = 0, lastPw = 0, bRun = 0, lastBusy = 0;
  logic prevDev = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sif_resync_reset #(.RUN_LEN(RUN), .SYNC_STAGES(2), .CLK_KHZ(KHZ), .LOCKOUT_US(LUS))
    i_sif_resync_reset (.sysClk(clk), .porN(porN), .sclk(sclk), .sdi(sdi), .csN(csN),
                        .devReset(devReset), .accessBusy(accessBusy));

  // monitor at the falling edge
  always @(negedge clk) begin
    if (porN) begin
      if (devReset && !prevDev) pulses++;
      if (devReset) pw++;
      else if (pw != 0) begin lastPw = pw; pw = 0; end
      if (accessBusy && !devReset) bRun++;
      else if (!accessBusy && bRun != 0) begin lastBusy = bRun; bRun = 0; end
      prevDev = devReset;
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b, input string req);
    bit expP;
    tick(); sclk = 1'b0; sdi = b;
    repeat (HALF) tick();
    sclk = 1'b1;
    expP = 1'b0;
    if (csN) mRun = 0;
    else if (mSkip > 0) mSkip--;
    else if (b) begin
      mRun++;
      if (mRun == RUN) begin expP = 1'b1; mRun = 0; mSkip = SKIP; mPulses++; end
    end else mRun = 0;
    repeat (3) tick();
    chk(devReset == expP, req, int'(devReset), int'(expP));
    tick();
  endtask

  task automatic selectPort();
    tick(); csN = 1'b0; repeat (3) tick();
  endtask

  task automatic deselectPort();
    tick(); sclk = 1'b0; csN = 1'b1;
    repeat (HOLD + 12) tick();
    mRun = 0; mSkip = 0;
  endtask

  task automatic ones(input int n, input string req);
    for (int i = 0; i < n; i++) sendBit(1'b1, req);
  endtask

  initial begin
    int p0;
    // R1 power-up
    repeat (3) tick();
    chk(devReset == 1'b1, "R1 pulse in reset", int'(devReset), 1);
    chk(accessBusy == 1'b1, "R1 busy in reset", int'(accessBusy), 1);
    porN = 1'b1;
    tick();
    chk(devReset == 1'b0, "R1 pulse after release", int'(devReset), 0);
    chk(accessBusy == 1'b1, "R1 busy after release", int'(accessBusy), 1);
    repeat (HOLD + 5) tick();
    chk(accessBusy == 1'b0, "R6 busy cleared", int'(accessBusy), 0);
    chk(lastBusy == HOLD + 1, "R6 power-up lockout", lastBusy, HOLD + 1);
    chk(pulses == 0, "R1 no extra pulse", pulses, 0);

    // sweep: R2 trigger point, R7 skipped bits, R9 retrigger
    for (int n = 0; n <= 70; n++) begin
      p0 = pulses; mPulses = 0;
      selectPort();
      ones(n, "R2/R9 run sweep");
      sendBit(1'b0, "R4 terminator");
      deselectPort();
      chk(pulses - p0 == mPulses, "R9 pulse count", pulses - p0, mPulses);
      if (mPulses > 0) begin
        chk(lastPw == 1, "R3 pulse width", lastPw, 1);
        chk(lastBusy == HOLD + 1, "R6 lockout", lastBusy, HOLD + 1);
      end
    end

    // R4: a zero breaks the run
    p0 = pulses; mPulses = 0;
    selectPort();
    ones(31, "R4 before zero");
    sendBit(1'b0, "R4 zero");
    ones(31, "R4 fresh run");
    sendBit(1'b1, "R4 32nd fresh one");
    deselectPort();
    chk(pulses - p0 == 1, "R4 single pulse", pulses - p0, 1);

    // R5: deselect breaks the run
    p0 = pulses; mPulses = 0;
    selectPort();
    ones(31, "R5 first part");
    deselectPort();
    selectPort();
    sendBit(1'b1, "R5 after reselect");
    chk(pulses - p0 == 0, "R5 no pulse", pulses - p0, 0);
    ones(31, "R5 completes fresh run");
    deselectPort();
    chk(pulses - p0 == 1, "R5 fresh run pulses", pulses - p0, 1);

    // R8: edges while deselected
    p0 = pulses;
    ones(40, "R8 deselected ones");
    repeat (5) tick();
    chk(pulses - p0 == 0, "R8 no pulse", pulses - p0, 0);
    chk(accessBusy == 1'b0, "R8 not busy", int'(accessBusy), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule